// File: doc/BRIEF.md
# SDRAM Mode-Driven Command Sequencer

This block sits between a simple register/bus port and the command pins of an SDR SDRAM. Software picks an operating mode through a small mode register. In normal mode a bus access becomes a row activate. A write or read with auto-precharge follows after the row-to-column delay. In any special mode, the next bus access into the SDRAM window is turned into exactly one command of the selected kind. The special kinds are NOP, precharge of all banks, auto-refresh and mode-register load. The data of that access is ignored.

The device power-up sequence is therefore run by software, one command per access: NOP, precharge-all, eight auto-refreshes, load-mode, then normal mode and one ordinary access. The address of a load-mode access carries the value written into the device mode register. After normal mode is restored, software arms a programmable refresh timer. The timer then requests periodic auto-refresh, and those requests win over waiting bus accesses. Every command is followed by a parameterised recovery window. The bus is stalled until the window has run out.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, sd_cmd_o is deselect (4'b1111), bus_ack_o and ready_o are 0, the mode is normal and periodic refresh is disabled, so an idle block issues no command.
- R2: A write with cfg_sel_i=0 loads the mode: 0 normal, 1 NOP, 2 precharge-all, 3 auto-refresh, 4 load-mode. A value above 4 is ignored and the previous mode stays.
- R3: In a special mode, each bus access issues exactly one command, with encoding {cs_n,ras_n,cas_n,we_n}: NOP 4'b0111, precharge 4'b0010, auto-refresh 4'b0001, load-mode 4'b0000. bus_we_i has no effect, and the unused address/bank outputs are 0.
- R4: A precharge command drives sd_a_o bit 10 high, so all banks close.
- R5: A load-mode command drives sd_a_o = bus_addr_i[BYTE_OFF +: ROW_W] and sd_ba_o = bus_addr_i[BYTE_OFF+ROW_W +: BA_W].
- R6: A normal access issues activate (4'b0011) with the row from bus_addr_i[BYTE_OFF+COL_W +: ROW_W] and the bank from the bits above it. Exactly T_RCD cycles later it issues write (4'b0100) or read (4'b0101), chosen by bus_we_i. That command carries the column in sd_a_o[COL_W-1:0] with bit 10 set and the same bank.
- R7: No command follows another sooner than its recovery: T_RP after precharge, write or read; T_RFC after auto-refresh; T_MRD after load-mode; 2 cycles after NOP.
- R8: bus_ack_o is a one-cycle pulse in the last recovery cycle of an access. Each access gets exactly one pulse.
- R9: A write with cfg_sel_i=1 sets the refresh period. A period of 0 disables refresh. A period N > T_RFC gives auto-refresh commands exactly N cycles apart while no access is running.
- R10: A pending refresh request is served before a waiting bus access. It never splits an activate from its write or read.
- R11: ready_o rises on the cycle after the ack of the first normal access that follows a load-mode command, and then stays high. A load-mode alone, or a normal access before any load-mode, leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects mode register, 1 selects refresh period |
| cfg_wdata_i | input | REF_W | Configuration write data |
| bus_req_i | input | 1 | Access request, held until ack |
| bus_we_i | input | 1 | Access direction for normal mode |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_ack_o | output | 1 | Access complete |
| ready_o | output | 1 | Initialisation complete flag |
| sd_cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_a_o | output | ROW_W | SDRAM address lines |
| sd_ba_o | output | BA_W | SDRAM bank lines |

## Verification
The bench uses the default geometry: 2 byte-offset bits, 9 column bits, 13 row bits and 2 bank bits. With this geometry the auto-precharge bit lies above the column field but inside the row field. It sets T_RCD=4, T_RP=3, T_RFC=6 and T_MRD=2, four distinct values, so a recovery window loaded for the wrong command shows up as a wrong spacing. Refresh periods of 12 and 20 cycles keep the periodic refresh inside a short window. The 20-cycle period lets a timer expiry land in a chain of back-to-back accesses, which exercises the refresh priority.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int unsigned AP_BIT = 10;

  typedef enum logic [2:0] {
    MODE_NORMAL    = 3'd0,
    MODE_NOP       = 3'd1,
    MODE_PRECHARGE = 3'd2,
    MODE_REFRESH   = 3'd3,
    MODE_LOADMODE  = 3'd4
  } mode_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_LMR   = 4'b0000
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECOV,
    ST_RDWR
  } state_e;

endpackage

// File: rtl/sdram_addr_map.sv
module sdram_addr_map
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned BYTE_OFF = 2,
  parameter int unsigned COL_W    = 9,
  parameter int unsigned ROW_W    = 13,
  parameter int unsigned BA_W     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [ROW_W-1:0]  col_a_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ROW_W-1:0]  lmr_a_o,
  output logic [BA_W-1:0]   lmr_ba_o
);

  localparam int unsigned ROW_LSB  = BYTE_OFF + COL_W;
  localparam int unsigned BANK_LSB = ROW_LSB + ROW_W;
  localparam int unsigned LBA_LSB  = BYTE_OFF + ROW_W;
  localparam int unsigned TOP_W    = ADDR_W - BANK_LSB - BA_W;

  always_comb begin
    row_o    = addr_i[ROW_LSB +: ROW_W];
    bank_o   = addr_i[BANK_LSB +: BA_W];
    lmr_a_o  = addr_i[BYTE_OFF +: ROW_W];
    lmr_ba_o = addr_i[LBA_LSB +: BA_W];
    col_a_o  = '0;
    col_a_o[COL_W-1:0] = addr_i[BYTE_OFF +: COL_W];
    col_a_o[AP_BIT]    = 1'b1;
  end

  // byte lane bits and bits above the bank field do not select a location
  if (BYTE_OFF > 0) begin : g_low
    logic unused_low;
    assign unused_low = ^addr_i[BYTE_OFF-1:0];
  end
  if (TOP_W > 0) begin : g_top
    logic unused_top;
    assign unused_top = ^addr_i[ADDR_W-1 -: TOP_W];
  end

endmodule

// File: rtl/sdram_wait_ctr.sv
module sdram_wait_ctr #(
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  output logic              done_o
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_load_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int unsigned REF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REF_W-1:0] cfg_val_i,
  input  logic             ack_i,
  output logic             pend_o
);

  logic [REF_W-1:0] period_q, cnt_q;
  logic             pend_q, expire;

  assign expire = !cfg_we_i && (period_q != '0) && (cnt_q <= REF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
    end else if (cfg_we_i) begin
      period_q <= cfg_val_i;
      cnt_q    <= cfg_val_i;
      pend_q   <= 1'b0;
    end else begin
      if (period_q != '0) cnt_q <= expire ? period_q : cnt_q - 1'b1;
      pend_q <= expire | (pend_q & ~ack_i);
    end
  end

  assign pend_o = pend_q;

  p_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q == '0) |-> !pend_o);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned BYTE_OFF = 2,
  parameter int unsigned COL_W    = 9,
  parameter int unsigned ROW_W    = 13,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned REF_W    = 12,
  parameter int unsigned T_RCD    = 3,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RFC    = 7,
  parameter int unsigned T_MRD    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [REF_W-1:0]  cfg_wdata_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              bus_ack_o,
  output logic              ready_o,
  output logic [3:0]        sd_cmd_o,
  output logic [ROW_W-1:0]  sd_a_o,
  output logic [BA_W-1:0]   sd_ba_o
);

  localparam int unsigned WAIT_W  = 8;
  localparam int unsigned T_NOP   = 2;
  localparam int unsigned MODE_MAX = 4;

  function automatic logic [WAIT_W-1:0] wait_of(input int unsigned t);
    return WAIT_W'(t - 2);
  endfunction

  state_e state_q, state_d;
  mode_e  mode_q;
  cmd_e   cmd_d, cmd_q;
  logic [ROW_W-1:0] a_d, a_q;
  logic [BA_W-1:0]  ba_d, ba_q;
  logic ack_pend_q, ack_pend_d, go_rdwr_q, go_rdwr_d, normal_q, normal_d;
  logic lmr_seen_q, ready_q, ack;
  logic wait_load, wait_done;
  logic [WAIT_W-1:0] wait_val;
  logic ref_pend, ref_ack;
  logic [ROW_W-1:0] row, col_a, lmr_a;
  logic [BA_W-1:0]  bank, lmr_ba;

  sdram_addr_map #(
    .ADDR_W(ADDR_W), .BYTE_OFF(BYTE_OFF), .COL_W(COL_W), .ROW_W(ROW_W), .BA_W(BA_W)
  ) i_map (
    .addr_i(bus_addr_i), .row_o(row), .col_a_o(col_a), .bank_o(bank),
    .lmr_a_o(lmr_a), .lmr_ba_o(lmr_ba)
  );

  sdram_wait_ctr #(.WAIT_W(WAIT_W)) i_wait (
    .clk_i, .rst_ni, .load_i(wait_load), .load_val_i(wait_val), .done_o(wait_done)
  );

  sdram_refresh_timer #(.REF_W(REF_W)) i_refresh (
    .clk_i, .rst_ni, .cfg_we_i(cfg_we_i & cfg_sel_i), .cfg_val_i(cfg_wdata_i),
    .ack_i(ref_ack), .pend_o(ref_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_NORMAL;
    else if (cfg_we_i && !cfg_sel_i && cfg_wdata_i <= REF_W'(MODE_MAX))
      mode_q <= mode_e'(cfg_wdata_i[2:0]);
  end

  always_comb begin
    state_d    = state_q;
    cmd_d      = CMD_DESEL;
    a_d        = '0;
    ba_d       = '0;
    wait_load  = 1'b0;
    wait_val   = '0;
    ref_ack    = 1'b0;
    ack        = 1'b0;
    ack_pend_d = ack_pend_q;
    go_rdwr_d  = go_rdwr_q;
    normal_d   = normal_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          cmd_d      = CMD_REF;
          wait_load  = 1'b1;
          wait_val   = wait_of(T_RFC);
          ref_ack    = 1'b1;
          ack_pend_d = 1'b0;
          go_rdwr_d  = 1'b0;
          normal_d   = 1'b0;
          state_d    = ST_RECOV;
        end else if (bus_req_i) begin
          wait_load  = 1'b1;
          ack_pend_d = 1'b1;
          go_rdwr_d  = 1'b0;
          normal_d   = 1'b0;
          state_d    = ST_RECOV;
          case (mode_q)
            MODE_NORMAL: begin
              cmd_d     = CMD_ACT;
              a_d       = row;
              ba_d      = bank;
              wait_val  = wait_of(T_RCD);
              go_rdwr_d = 1'b1;
              normal_d  = 1'b1;
            end
            MODE_PRECHARGE: begin
              cmd_d         = CMD_PRE;
              a_d[AP_BIT]   = 1'b1;
              wait_val      = wait_of(T_RP);
            end
            MODE_REFRESH: begin
              cmd_d    = CMD_REF;
              wait_val = wait_of(T_RFC);
            end
            MODE_LOADMODE: begin
              cmd_d    = CMD_LMR;
              a_d      = lmr_a;
              ba_d     = lmr_ba;
              wait_val = wait_of(T_MRD);
            end
            default: begin
              cmd_d    = CMD_NOP;
              wait_val = wait_of(T_NOP);
            end
          endcase
        end
      end
      ST_RECOV: begin
        if (wait_done) begin
          if (go_rdwr_q) begin
            state_d = ST_RDWR;
          end else begin
            state_d    = ST_IDLE;
            ack        = ack_pend_q;
            ack_pend_d = 1'b0;
          end
        end
      end
      ST_RDWR: begin
        cmd_d     = bus_we_i ? CMD_WRITE : CMD_READ;
        a_d       = col_a;
        ba_d      = bank;
        wait_load = 1'b1;
        wait_val  = wait_of(T_RP);
        go_rdwr_d = 1'b0;
        state_d   = ST_RECOV;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cmd_q      <= CMD_DESEL;
      a_q        <= '0;
      ba_q       <= '0;
      ack_pend_q <= 1'b0;
      go_rdwr_q  <= 1'b0;
      normal_q   <= 1'b0;
      lmr_seen_q <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      cmd_q      <= cmd_d;
      a_q        <= a_d;
      ba_q       <= ba_d;
      ack_pend_q <= ack_pend_d;
      go_rdwr_q  <= go_rdwr_d;
      normal_q   <= normal_d;
      lmr_seen_q <= lmr_seen_q | (cmd_d == CMD_LMR);
      ready_q    <= ready_q | (ack & normal_q & lmr_seen_q);
    end
  end

  assign sd_cmd_o  = cmd_q;
  assign sd_a_o    = a_q;
  assign sd_ba_o   = ba_q;
  assign bus_ack_o = ack;
  assign ready_o   = ready_q;

  // command spacing tracker, observes the pins only
  logic [WAIT_W-1:0] gap_q, need_q;
  logic              seen_q;
  cmd_e              last_q;

  function automatic logic [WAIT_W-1:0] need_of(input logic [3:0] c);
    case (c)
      CMD_PRE, CMD_READ, CMD_WRITE: return WAIT_W'(T_RP);
      CMD_REF:                      return WAIT_W'(T_RFC);
      CMD_LMR:                      return WAIT_W'(T_MRD);
      CMD_ACT:                      return WAIT_W'(T_RCD);
      default:                      return WAIT_W'(T_NOP);
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      need_q <= '0;
      seen_q <= 1'b0;
      last_q <= CMD_DESEL;
    end else if (sd_cmd_o != CMD_DESEL) begin
      gap_q  <= WAIT_W'(1);
      need_q <= need_of(sd_cmd_o);
      seen_q <= 1'b1;
      last_q <= cmd_e'(sd_cmd_o);
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_cmd_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && sd_cmd_o != CMD_DESEL) |-> (gap_q >= need_q));

  p_rcd_exact_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_cmd_o == CMD_WRITE || sd_cmd_o == CMD_READ) |->
      (last_q == CMD_ACT && gap_q == WAIT_W'(T_RCD)));

  p_pre_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_cmd_o == CMD_PRE) |-> sd_a_o[AP_BIT]);

  p_ack_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !bus_ack_o);

  p_ready_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_ready_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> lmr_seen_q);

endmodule

// File: tb/test_sdram_cmd_seq.sv
`timescale 1ns/1ps
module test_sdram_cmd_seq;
  import sdram_seq_pkg::*;

  localparam int unsigned ADDR_W = 26, BYTE_OFF = 2, COL_W = 9, ROW_W = 13, BA_W = 2;
  localparam int unsigned REF_W = 12, T_RCD = 4, T_RP = 3, T_RFC = 6, T_MRD = 2;
  localparam int LOG_N = 512;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [REF_W-1:0] cfg_wdata_i = '0;
  logic bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic bus_ack_o, ready_o;
  logic [3:0] sd_cmd_o;
  logic [ROW_W-1:0] sd_a_o;
  logic [BA_W-1:0] sd_ba_o;

  sdram_cmd_seq #(
    .ADDR_W(ADDR_W), .BYTE_OFF(BYTE_OFF), .COL_W(COL_W), .ROW_W(ROW_W), .BA_W(BA_W),
    .REF_W(REF_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) i_sdram_cmd_seq (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0, n_log = 0;
  logic [3:0]       lg_cmd [LOG_N];
  logic [ROW_W-1:0] lg_a   [LOG_N];
  logic [BA_W-1:0]  lg_ba  [LOG_N];
  int               lg_t   [LOG_N];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int need_of(input logic [3:0] c);
    case (c)
      4'b0010, 4'b0100, 4'b0101: return T_RP;
      4'b0001: return T_RFC;
      4'b0000: return T_MRD;
      4'b0011: return T_RCD;
      default: return 2;
    endcase
  endfunction

  // command log and spacing check (R7)
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && sd_cmd_o != 4'b1111 && n_log < LOG_N) begin
      if (n_log > 0)
        chk(cyc - lg_t[n_log-1] >= need_of(lg_cmd[n_log-1]), "R7", "command spacing",
            cyc - lg_t[n_log-1], need_of(lg_cmd[n_log-1]));
      lg_cmd[n_log] = sd_cmd_o;
      lg_a[n_log]   = sd_a_o;
      lg_ba[n_log]  = sd_ba_o;
      lg_t[n_log]   = cyc;
      n_log++;
    end
  end

  task automatic cfg_write(input logic sel, input logic [REF_W-1:0] val);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = val;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic access(input logic [ADDR_W-1:0] addr, input logic we, input bit keep,
                        output int first, output int ncmd);
    bit got = 0;
    bus_addr_i = addr; bus_we_i = we; bus_req_i = 1'b1;
    @(posedge clk_i);
    first = n_log;
    for (int k = 0; k < 200 && !got; k++) begin
      @(negedge clk_i);
      if (bus_ack_o) got = 1;
    end
    chk(got, "R8", "ack seen", got, 1);
    bus_req_i = keep;
    #1;
    ncmd = n_log - first;
  endtask

  function automatic logic [ADDR_W-1:0] mk(input logic [BA_W-1:0] b,
      input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    return {b, r, c, 2'b00};
  endfunction

  typedef struct packed {
    logic [2:0]        mode;
    logic [ADDR_W-1:0] addr;
    logic              we;
    logic [3:0]        cmd;
    logic [ROW_W-1:0]  a;
    logic [BA_W-1:0]   ba;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{3'd1, 26'h3FFFFFC, 1'b1, 4'b0111, 13'h0000, 2'd0},
    '{3'd2, 26'h0000124, 1'b0, 4'b0010, 13'h0400, 2'd0},
    '{3'd3, 26'h0000004, 1'b1, 4'b0001, 13'h0000, 2'd0},
    '{3'd3, 26'h0000008, 1'b0, 4'b0001, 13'h0000, 2'd0},
    '{3'd3, 26'h000000C, 1'b1, 4'b0001, 13'h0000, 2'd0},
    '{3'd3, 26'h0000010, 1'b0, 4'b0001, 13'h0000, 2'd0},
    '{3'd3, 26'h0000014, 1'b1, 4'b0001, 13'h0000, 2'd0},
    '{3'd3, 26'h0000018, 1'b0, 4'b0001, 13'h0000, 2'd0},
    '{3'd3, 26'h000001C, 1'b1, 4'b0001, 13'h0000, 2'd0},
    '{3'd3, 26'h0000020, 1'b0, 4'b0001, 13'h0000, 2'd0},
    '{3'd4, 26'h00000CC, 1'b1, 4'b0000, 13'h0033, 2'd0},
    '{3'd4, 26'h0010694, 1'b0, 4'b0000, 13'h01A5, 2'd2}
  };

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 30000, 0);
    summary();
  end

  initial begin
    int fi, nc, snap, nref, cstart, cend;
    string tag;
    // R1 reset state
    repeat (4) @(negedge clk_i);
    chk(sd_cmd_o == 4'b1111, "R1", "cmd in reset", sd_cmd_o, 4'hF);
    chk(!bus_ack_o, "R1", "ack in reset", bus_ack_o, 0);
    chk(!ready_o, "R1", "ready in reset", ready_o, 0);
    rst_ni = 1'b1;
    repeat (30) @(negedge clk_i);
    chk(n_log == 0, "R1", "idle commands", n_log, 0);

    // R6 normal write and read before any load-mode
    access(mk(2'd3, 13'h0A5C, 9'h1F3), 1'b1, 0, fi, nc);
    chk(nc == 2, "R6", "write cmd count", nc, 2);
    chk(lg_cmd[fi] == 4'b0011, "R6", "activate", lg_cmd[fi], 4'b0011);
    chk(lg_a[fi] == 13'h0A5C, "R6", "row", lg_a[fi], 13'h0A5C);
    chk(lg_ba[fi] == 2'd3, "R6", "act bank", lg_ba[fi], 3);
    chk(lg_cmd[fi+1] == 4'b0100, "R6", "write", lg_cmd[fi+1], 4'b0100);
    chk(lg_a[fi+1] == 13'h05F3, "R6", "column", lg_a[fi+1], 13'h05F3);
    chk(lg_ba[fi+1] == 2'd3, "R6", "wr bank", lg_ba[fi+1], 3);
    chk(lg_t[fi+1] - lg_t[fi] == T_RCD, "R6", "tRCD", lg_t[fi+1] - lg_t[fi], T_RCD);
    @(negedge clk_i);
    chk(!bus_ack_o, "R8", "ack pulse", bus_ack_o, 0);
    chk(!ready_o, "R11", "ready before load-mode", ready_o, 0);

    access(mk(2'd1, 13'h1FFF, 9'h000), 1'b0, 0, fi, nc);
    chk(nc == 2, "R6", "read cmd count", nc, 2);
    chk(lg_a[fi] == 13'h1FFF && lg_ba[fi] == 2'd1, "R6", "read row", lg_a[fi], 13'h1FFF);
    chk(lg_cmd[fi+1] == 4'b0101, "R6", "read", lg_cmd[fi+1], 4'b0101);
    chk(lg_a[fi+1] == 13'h0400, "R6", "read column", lg_a[fi+1], 13'h0400);

    // R2 out-of-range mode values are ignored
    @(negedge clk_i);
    cfg_write(0, 12'd7);
    access(mk(2'd0, 13'h0011, 9'h022), 1'b1, 0, fi, nc);
    chk(lg_cmd[fi] == 4'b0011, "R2", "value 7 ignored", lg_cmd[fi], 4'b0011);
    @(negedge clk_i);
    cfg_write(0, 12'd2);
    cfg_write(0, 12'd5);
    access(26'h0, 1'b1, 0, fi, nc);
    chk(nc == 1 && lg_cmd[fi] == 4'b0010, "R2", "value 5 ignored", lg_cmd[fi], 4'b0010);

    // R3 R4 R5 special-mode table walk: power-up order
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      cfg_write(0, REF_W'(VECS[i].mode));
      access(VECS[i].addr, VECS[i].we, 0, fi, nc);
      tag = (VECS[i].mode == 3'd2) ? "R4" : (VECS[i].mode == 3'd4) ? "R5" : "R3";
      chk(nc == 1, "R3", "one command", nc, 1);
      chk(lg_cmd[fi] == VECS[i].cmd, "R3", "command code", lg_cmd[fi], VECS[i].cmd);
      chk(lg_a[fi] == VECS[i].a, tag, "address lines", lg_a[fi], VECS[i].a);
      chk(lg_ba[fi] == VECS[i].ba, tag, "bank lines", lg_ba[fi], VECS[i].ba);
      @(negedge clk_i);
      chk(!bus_ack_o, "R8", "single ack", bus_ack_o, 0);
      chk(!ready_o, "R11", "ready during init", ready_o, 0);
    end

    // R11 first normal access after load-mode
    cfg_write(0, 12'd0);
    access(mk(2'd2, 13'h0100, 9'h055), 1'b1, 0, fi, nc);
    @(negedge clk_i);
    chk(ready_o, "R11", "ready after access", ready_o, 1);
    access(mk(2'd0, 13'h0001, 9'h001), 1'b0, 0, fi, nc);
    @(negedge clk_i);
    chk(ready_o, "R11", "ready sticky", ready_o, 1);

    // R9 periodic refresh
    snap = n_log;
    cfg_write(1, 12'd12);
    repeat (62) @(negedge clk_i);
    nref = 0;
    for (int j = snap; j < n_log; j++) begin
      if (lg_cmd[j] == 4'b0001) begin
        if (nref > 0)
          chk(lg_t[j] - lg_t[cstart] == 12, "R9", "refresh period", lg_t[j] - lg_t[cstart], 12);
        cstart = j;
        nref++;
      end
    end
    chk(nref >= 4, "R9", "refresh count", nref, 4);
    cfg_write(1, 12'd0);
    repeat (8) @(negedge clk_i);
    snap = n_log;
    repeat (40) @(negedge clk_i);
    chk(n_log == snap, "R9", "refresh disabled", n_log - snap, 0);

    // R10 refresh wins over a waiting access
    cfg_write(1, 12'd20);
    snap = n_log;
    for (int k = 0; k < 100 && n_log == snap; k++) @(negedge clk_i);
    repeat (13) @(negedge clk_i);
    access(mk(2'd0, 13'h0002, 9'h003), 1'b1, 1, cstart, nc);
    access(mk(2'd1, 13'h0004, 9'h005), 1'b1, 1, fi, nc);
    access(mk(2'd2, 13'h0006, 9'h007), 1'b1, 1, fi, nc);
    access(mk(2'd3, 13'h0008, 9'h009), 1'b1, 0, fi, nc);
    cend = n_log;
    nref = 0;
    for (int j = cstart + 1; j < cend - 1; j++) begin
      if (lg_cmd[j] == 4'b0001) begin
        nref++;
        chk(lg_cmd[j-1] == 4'b0100, "R10", "refresh after write", lg_cmd[j-1], 4'b0100);
        chk(lg_cmd[j+1] == 4'b0011, "R10", "access after refresh", lg_cmd[j+1], 4'b0011);
      end
    end
    chk(nref >= 1, "R10", "refresh inside chain", nref, 1);
    cfg_write(1, 12'd0);
    repeat (10) @(negedge clk_i);
    summary();
  end

endmodule